// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block is the device-side ownership logic of a security coprocessor whose host interface is split into five address windows, one per locality. Each window holds a byte-wide access register. Software in a locality asks for the device by writing a request bit into its own access register. It hands the device back by writing the active bit. The arbiter lets exactly one locality own the device at a time. It reports ownership and any queued request through every window's access register.

A locality that asks while another one owns the device is marked pending. When the owner lets go, the lowest-numbered pending locality takes over on the same clock edge. The host port is a plain synchronous write strobe with address and byte data. Reads decode the address combinationally, so software can poll for a grant or a release.

Top module: `loc_access_arbiter`

## Requirements
- R1: The window index is address bits [14:12], and the access register sits at offset 0 of the window (address bits [11:0] all zero). Windows 5 to 7 and all other offsets ignore writes and read 0x00.
- R2: In an access register, bit 7 reads 1, bit 5 reads 1 only for the owning locality, and bit 2 reads 1 only for a pending locality. Bits 6, 4, 3, 1 and 0 always read 0, whatever was written.
- R3: After reset no locality owns the device and none is pending, so every access register reads 0x80.
- R4: With no owner, a write with bit 1 set makes that locality the owner. The access register shows this from the clock edge that takes the write.
- R5: A write with bit 1 set from a non-owner while another locality owns the device sets the writer's pending bit and leaves the owner unchanged.
- R6: A write with bit 1 set (and bit 5 clear) from the current owner changes neither ownership nor any pending bit.
- R7: A write with bit 5 set from the owner releases ownership, and its bit 5 reads 0 after that edge. A write with bit 5 set from a non-owner does not release the device.
- R8: On a release, the lowest-index pending locality becomes the owner on the same edge and its pending bit clears. With nothing pending the device becomes free.
- R9: At most one locality owns the device at any time, and the owner is never also pending.
- R10: A write with both bit 5 and bit 1 set acts as a release when it comes from the owner, and as a request when it comes from any other locality.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one write per asserted cycle |
| addr | input | 15 | Byte address; bits [14:12] select the window |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed register, combinational |

## Verification
Every write takes effect on the rising edge that samples it. Reads are combinational, so each result is due zero cycles after the edge following the write. The driver changes inputs 1 ns after a rising edge and queues the value it expects. The monitor compares at the next falling edge, which is always after the write edge and before the next one. Release handover, pending queuing and ignored writes are all observed through the access registers of the affected windows in the cycle right after the write.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int LOC_W      = 3;
  localparam int BIT_VALID  = 7;
  localparam int BIT_ACTIVE = 5;
  localparam int BIT_PEND   = 2;
  localparam int BIT_REQ    = 1;

  // Strobes from the decoder to the ownership state.
  typedef struct packed {
    logic             reqHit;
    logic             relHit;
    logic [LOC_W-1:0] loc;
  } arbStrobe_t;
endpackage

// File: rtl/loc_arb_ctrl.sv
module loc_arb_ctrl
  import loc_arb_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int WIN_LSB = 12,
  parameter int NUM_LOC = 5
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output arbStrobe_t        strb,
  output logic              rdHit,
  output logic [LOC_W-1:0]  rdLoc
);
  localparam int WIN_W = ADDR_W - WIN_LSB;

  logic [WIN_W-1:0] winIdx;
  logic             offZero;
  logic             winHit;

  assign winIdx  = addr[ADDR_W-1:WIN_LSB];
  assign offZero = (addr[WIN_LSB-1:0] == '0);
  assign winHit  = offZero && (int'(winIdx) < NUM_LOC);

  assign rdHit = winHit;
  assign rdLoc = LOC_W'(winIdx);

  always_comb begin
    strb.loc    = LOC_W'(winIdx);
    strb.reqHit = wrEn && winHit && wrData[BIT_REQ];
    strb.relHit = wrEn && winHit && wrData[BIT_ACTIVE];
  end
endmodule

// File: rtl/loc_arb_dp.sv
module loc_arb_dp
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  arbStrobe_t         strb,
  input  logic               rdHit,
  input  logic [LOC_W-1:0]   rdLoc,
  output logic [7:0]         rdData,
  output logic [NUM_LOC-1:0] ownerVec,
  output logic [NUM_LOC-1:0] pendVec
);
  logic [NUM_LOC-1:0] locBit;
  logic [NUM_LOC-1:0] nextOwner;
  logic [NUM_LOC-1:0] nextPend;
  logic [NUM_LOC-1:0] lowPend;
  logic               isOwner;
  logic [7:0]         accByte [NUM_LOC];

  assign locBit  = {{(NUM_LOC-1){1'b0}}, 1'b1} << strb.loc;
  assign isOwner = |(ownerVec & locBit);
  assign lowPend = pendVec & (~pendVec + {{(NUM_LOC-1){1'b0}}, 1'b1});

  always_comb begin
    nextOwner = ownerVec;
    nextPend  = pendVec;
    if (strb.relHit && isOwner) begin
      nextOwner = lowPend;
      nextPend  = pendVec & ~lowPend;
    end else if (strb.reqHit && !isOwner) begin
      if (ownerVec == '0) nextOwner = locBit;
      else                nextPend  = pendVec | locBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownerVec <= '0;
      pendVec  <= '0;
    end else begin
      ownerVec <= nextOwner;
      pendVec  <= nextPend;
    end
  end

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_acc
    always_comb begin
      accByte[i]             = 8'h00;
      accByte[i][BIT_VALID]  = 1'b1;
      accByte[i][BIT_ACTIVE] = ownerVec[i];
      accByte[i][BIT_PEND]   = pendVec[i];
    end
  end

  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (rdHit && (int'(rdLoc) == i)) rdData = accByte[i];
    end
  end
endmodule

// File: rtl/loc_access_arbiter.sv
module loc_access_arbiter
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int ADDR_W  = 15,
  parameter int WIN_LSB = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData
);
  arbStrobe_t         strb;
  logic               rdHit;
  logic [LOC_W-1:0]   rdLoc;
  logic [NUM_LOC-1:0] ownerVec;
  logic [NUM_LOC-1:0] pendVec;

  loc_arb_ctrl #(
    .ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB), .NUM_LOC(NUM_LOC)
  ) ctrl_i (
    .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .strb(strb), .rdHit(rdHit), .rdLoc(rdLoc)
  );

  loc_arb_dp #(.NUM_LOC(NUM_LOC)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdHit(rdHit), .rdLoc(rdLoc),
    .rdData(rdData), .ownerVec(ownerVec), .pendVec(pendVec)
  );
endmodule

// File: rtl/loc_arb_chk.sv
module loc_arb_chk
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5
) (
  input logic               clk,
  input logic               rstN,
  input arbStrobe_t         strb,
  input logic [NUM_LOC-1:0] ownerVec,
  input logic [NUM_LOC-1:0] pendVec,
  input logic [7:0]         rdData
);
  logic [NUM_LOC-1:0] strbBit;
  logic               strbIsOwner;
  assign strbBit     = {{(NUM_LOC-1){1'b0}}, 1'b1} << strb.loc;
  assign strbIsOwner = |(ownerVec & strbBit);

  p_one_owner_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ownerVec));

  p_owner_not_pending_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ownerVec & pendVec) == '0);

  p_grant_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.reqHit && !strb.relHit && ownerVec == '0) |=> ownerVec == $past(strbBit));

  p_pending_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.reqHit && ownerVec != '0 && !strbIsOwner)
      |=> ((pendVec & $past(strbBit)) != '0) && $stable(ownerVec));

  p_owner_req_noop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.reqHit && !strb.relHit && strbIsOwner) |=> $stable(ownerVec) && $stable(pendVec));

  p_release_free_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.relHit && strbIsOwner && pendVec == '0) |=> ownerVec == '0);

  p_handover_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.relHit && strbIsOwner && pendVec != '0)
      |=> $countones(ownerVec) == 1 && (ownerVec & $past(pendVec)) != '0);

  p_fixed_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdData != 8'h00) |-> (rdData[BIT_VALID] && (rdData & 8'h5B) == 8'h00));
endmodule

bind loc_access_arbiter loc_arb_chk #(.NUM_LOC(NUM_LOC)) chk_i (
  .clk(clk), .rstN(rstN), .strb(strb),
  .ownerVec(ownerVec), .pendVec(pendVec), .rdData(rdData)
);

// File: tb/loc_access_arbiter_tb_top.sv
module loc_access_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [14:0] qAddr [$];
  logic [7:0]  qExp  [$];
  string       qTag  [$];

  always #5 clk = ~clk;

  loc_access_arbiter dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData)
  );

  // Driver: inputs change 1 ns after a rising edge.
  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; addr = a; wrData = d;
  endtask

  task automatic rd(input logic [14:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    wrEn = 1'b0; addr = a; wrData = 8'h00;
    qAddr.push_back(a); qExp.push_back(e); qTag.push_back(tag);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  // Monitor: compares at the falling edge after each queued read.
  always @(negedge clk) begin
    if (qExp.size() > 0) begin
      logic [14:0] a;
      logic [7:0]  e;
      string       t;
      a = qAddr.pop_front(); e = qExp.pop_front(); t = qTag.pop_front();
      checks++;
      if (rdData !== e) begin
        failures++;
        $display("FAIL %s addr=%h actual=%h expected=%h", t, a, rdData, e);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R3: reset state
    for (int i = 0; i < 5; i++) rd(15'(i) << 12, 8'h80, "R3 reset");
    // R1: unmapped window and offset
    rd(15'h5000, 8'h00, "R1 window5 read");
    rd(15'h0004, 8'h00, "R1 offset read");
    // R4: grant when free
    wr(15'h2000, 8'h02);
    rd(15'h2000, 8'hA0, "R4 grant loc2");
    rd(15'h1000, 8'h80, "R2 nonowner view");
    // R6: owner request has no effect
    wr(15'h2000, 8'h02);
    rd(15'h2000, 8'hA0, "R6 owner req");
    // R5: pending
    wr(15'h4000, 8'h02);
    rd(15'h4000, 8'h84, "R5 loc4 pending");
    rd(15'h2000, 8'hA0, "R5 owner kept");
    wr(15'h1000, 8'h02);
    rd(15'h1000, 8'h84, "R5 loc1 pending");
    // R1: ignored writes
    wr(15'h5000, 8'h02);
    rd(15'h5000, 8'h00, "R1 window5 write");
    wr(15'h0004, 8'h02);
    rd(15'h0000, 8'h80, "R1 offset write");
    // R7: release by non-owner ignored
    wr(15'h4000, 8'h20);
    rd(15'h2000, 8'hA0, "R7 nonowner release");
    rd(15'h4000, 8'h84, "R7 nonowner pend kept");
    // R8: release hands to lowest pending
    wr(15'h2000, 8'h20);
    rd(15'h2000, 8'h80, "R7 owner released");
    rd(15'h1000, 8'hA0, "R8 lowest pending granted");
    rd(15'h4000, 8'h84, "R8 higher still pending");
    // R10: both bits from owner act as release
    wr(15'h1000, 8'h22);
    rd(15'h1000, 8'h80, "R10 owner both bits");
    rd(15'h4000, 8'hA0, "R8 next pending granted");
    // R7: release with nothing pending frees device
    wr(15'h4000, 8'h20);
    for (int i = 0; i < 5; i++) rd(15'(i) << 12, 8'h80, "R7 device free");
    // R10, R2: both bits from non-owner act as request; other bits ignored
    wr(15'h0000, 8'hFF);
    rd(15'h0000, 8'hA0, "R10 nonowner both bits");
    wr(15'h3000, 8'hDF);
    rd(15'h3000, 8'h84, "R2 extra bits ignored");
    rd(15'h0000, 8'hA0, "R9 single owner");
    wr(15'h0000, 8'h20);
    rd(15'h3000, 8'hA0, "R8 loc3 granted");
    rd(15'h0000, 8'h80, "R9 old owner cleared");
    idle();
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule